// File: doc/BRIEF.md
# Positive Justification Tributary Demultiplexer

This block sits behind a frame aligner on the receive side of a four-tributary, bit-interleaved high-order multiplex. Each cycle it takes one line bit together with a valid flag, the bit's position inside the frame, and the aligner's loss-of-frame flag. From these it recovers four tributary bit streams. Each stream comes with a one-cycle write strobe that feeds a downstream elastic store.

The frame is made of NUM_CTRL+1 equal groups of GROUP_LEN bits. The first group opens with HDR_BITS service bits: alignment word, remote alarm and national bits. Every later group opens with one justification control bit per tributary, in tributary order. In the last group those control bits are followed immediately by one justification opportunity bit per tributary. All remaining bits are tributary data, interleaved one bit at a time in tributary order 0,1,2,3.

For each tributary the block counts the ones in its control bits across the frame and makes the stuffing decision by majority vote at the final control bit. That decision then governs the same tributary's opportunity bit in the same frame. When stuffing is signalled the opportunity bit is discarded; otherwise it is delivered as data.

Top module: `posJustDemux`

## Requirements
- R1: After reset all write strobes and all tributary data outputs are 0.
- R2: The first HDR_BITS positions of group 0 (frame positions 0 to HDR_BITS-1) never raise any write strobe.
- R3: A data bit at frame position p is presented on tributary (p mod GROUP_LEN) mod NUM_TRIB one cycle later, with that tributary's write strobe high, and no other strobe is high.
- R4: Control bits, which occupy offsets 0 to NUM_TRIB-1 of groups 1 to NUM_CTRL (tributary = offset), never raise a write strobe.
- R5: If three or more of a tributary's five control bits in a frame are 1, its opportunity bit is not written. The opportunity bit sits at offset NUM_TRIB+t of group NUM_CTRL for tributary t.
- R6: If two or fewer of a tributary's control bits are 1, its opportunity bit is written as data to that tributary one cycle later.
- R7: The vote taken in a frame applies only to that frame's opportunity bit; the next frame's opportunity bit follows that next frame's own control bits.
- R8: While loss of frame is high, no write strobe rises in the following cycle.
- R9: A cycle with inValid low raises no strobe and does not change any vote count.
- R10: At most one write strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Aligned line bit |
| inValid | input | 1 | inBit and framePos are meaningful this cycle |
| framePos | input | POS_W | Position of inBit within the frame, 0 to FRAME_LEN-1 |
| lof | input | 1 | Loss of frame from the aligner |
| tribData | output | NUM_TRIB | Latest bit delivered to each tributary |
| tribWe | output | NUM_TRIB | One-cycle write strobe per tributary |

## Verification
The hardest behaviour to reach is a vote that changes from one frame to the next while carrying a minority of corrupted control bits. Reaching it needs every five-bit control code on every tributary across consecutive frames. The bench therefore runs a shortened frame (twenty-bit groups) and steps the control code per frame with a stride coprime to 32, so each tributary passes through all 32 codes. Every tributary starts from a different offset. Idle cycles present a 1 at control positions to expose any counting while inValid is low. A loss-of-frame window spans a voting group to show that strobes are gated while voting continues.

// File: rtl/demuxPkg.sv
package demuxPkg;

  // Wide enough for up to 16 tributaries.
  localparam int TRIB_IDX_W = 4;

  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_DATA,
    SLOT_CTRL,
    SLOT_VOTE,
    SLOT_OPP
  } slotKind_t;

  typedef struct packed {
    slotKind_t               kind;
    logic                    firstCtrl;
    logic                    wrOk;
    logic [TRIB_IDX_W-1:0]   trib;
  } slotStrobe_t;

endpackage

// File: rtl/demuxCtrl.sv
module demuxCtrl
  import demuxPkg::*;
#(
  parameter int NUM_TRIB  = 4,
  parameter int GROUP_LEN = 488,
  parameter int NUM_CTRL  = 5,
  parameter int HDR_BITS  = 16,
  parameter int POS_W     = 12
) (
  input  logic             inValid,
  input  logic             lof,
  input  logic [POS_W-1:0] framePos,
  output slotStrobe_t      strobe
);

  localparam int FRAME_LEN = GROUP_LEN * (NUM_CTRL + 1);

  int posI;
  int grpI;
  int offI;

  assign posI = int'(framePos);
  assign grpI = posI / GROUP_LEN;
  assign offI = posI % GROUP_LEN;

  always_comb begin
    strobe.kind      = SLOT_IDLE;
    strobe.firstCtrl = (grpI == 1);
    strobe.wrOk      = !lof;
    strobe.trib      = TRIB_IDX_W'(offI % NUM_TRIB);
    if (inValid && posI < FRAME_LEN) begin
      if (grpI == 0) begin
        strobe.kind = (offI < HDR_BITS) ? SLOT_IDLE : SLOT_DATA;
      end else if (offI < NUM_TRIB) begin
        strobe.kind = (grpI == NUM_CTRL) ? SLOT_VOTE : SLOT_CTRL;
      end else if (grpI == NUM_CTRL && offI < 2 * NUM_TRIB) begin
        strobe.kind = SLOT_OPP;
      end else begin
        strobe.kind = SLOT_DATA;
      end
    end
  end

endmodule

// File: rtl/demuxData.sv
module demuxData
  import demuxPkg::*;
#(
  parameter int NUM_TRIB = 4,
  parameter int NUM_CTRL = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inBit,
  input  slotStrobe_t         strobe,
  output logic [NUM_TRIB-1:0] tribData,
  output logic [NUM_TRIB-1:0] tribWe
);

  localparam int CNT_W    = $clog2(NUM_CTRL + 1);
  localparam int VOTE_MIN = NUM_CTRL / 2 + 1;

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
    logic [CNT_W-1:0] onesCnt;
    logic [CNT_W-1:0] onesSum;
    logic             stuffQ;
    logic             dataQ;
    logic             weQ;
    logic             hit;

    assign hit     = (strobe.trib == TRIB_IDX_W'(t)) && (strobe.kind != SLOT_IDLE);
    assign onesSum = onesCnt + CNT_W'(inBit);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        onesCnt <= '0;
        stuffQ  <= 1'b0;
        dataQ   <= 1'b0;
        weQ     <= 1'b0;
      end else begin
        weQ <= 1'b0;
        if (hit) begin
          unique case (strobe.kind)
            SLOT_DATA: begin
              dataQ <= inBit;
              weQ   <= strobe.wrOk;
            end
            SLOT_CTRL: begin
              onesCnt <= strobe.firstCtrl ? CNT_W'(inBit) : onesSum;
            end
            SLOT_VOTE: begin
              stuffQ  <= (onesSum >= CNT_W'(VOTE_MIN));
              onesCnt <= '0;
            end
            SLOT_OPP: begin
              if (!stuffQ) begin
                dataQ <= inBit;
                weQ   <= strobe.wrOk;
              end
            end
            default: ;
          endcase
        end
      end
    end

    assign tribData[t] = dataQ;
    assign tribWe[t]   = weQ;
  end

endmodule

// File: rtl/posJustDemux.sv
module posJustDemux
  import demuxPkg::*;
#(
  parameter  int NUM_TRIB  = 4,
  parameter  int GROUP_LEN = 488,
  parameter  int NUM_CTRL  = 5,
  parameter  int HDR_BITS  = 16,
  localparam int FRAME_LEN = GROUP_LEN * (NUM_CTRL + 1),
  localparam int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inBit,
  input  logic                inValid,
  input  logic [POS_W-1:0]    framePos,
  input  logic                lof,
  output logic [NUM_TRIB-1:0] tribData,
  output logic [NUM_TRIB-1:0] tribWe
);

  slotStrobe_t strobe;

  demuxCtrl #(
    .NUM_TRIB(NUM_TRIB), .GROUP_LEN(GROUP_LEN), .NUM_CTRL(NUM_CTRL),
    .HDR_BITS(HDR_BITS), .POS_W(POS_W)
  ) uCtrl (
    .inValid(inValid), .lof(lof), .framePos(framePos), .strobe(strobe)
  );

  demuxData #(
    .NUM_TRIB(NUM_TRIB), .NUM_CTRL(NUM_CTRL)
  ) uData (
    .clk(clk), .rstN(rstN), .inBit(inBit), .strobe(strobe),
    .tribData(tribData), .tribWe(tribWe)
  );

endmodule

// File: rtl/demuxChk.sv
module demuxChk #(
  parameter int NUM_TRIB  = 4,
  parameter int GROUP_LEN = 488,
  parameter int HDR_BITS  = 16,
  parameter int POS_W     = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                inBit,
  input logic                inValid,
  input logic [POS_W-1:0]    framePos,
  input logic                lof,
  input logic [NUM_TRIB-1:0] tribData,
  input logic [NUM_TRIB-1:0] tribWe
);

  // R10
  onehot_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tribWe));

  // R8
  lof_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    lof |=> (tribWe == '0));

  // R9
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (tribWe == '0));

  // R2
  header_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && int'(framePos) < HDR_BITS) |=> (tribWe == '0));

  // R4
  ctrl_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (int'(framePos) % GROUP_LEN) < NUM_TRIB) |=> (tribWe == '0));

  // R3
  first_group_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !lof && int'(framePos) >= HDR_BITS && int'(framePos) < GROUP_LEN)
    |=> ($countones(tribWe) == 1)
        && tribWe[$past(int'(framePos)) % NUM_TRIB]
        && (tribData[$past(int'(framePos)) % NUM_TRIB] == $past(inBit)));

endmodule

bind posJustDemux demuxChk #(
  .NUM_TRIB(NUM_TRIB), .GROUP_LEN(GROUP_LEN), .HDR_BITS(HDR_BITS), .POS_W(POS_W)
) uChk (
  .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid), .framePos(framePos),
  .lof(lof), .tribData(tribData), .tribWe(tribWe)
);

// File: tb/sim_posJustDemux.sv
`timescale 1ns/1ps
module sim_posJustDemux;

  localparam int NT = 4;
  localparam int G  = 20;
  localparam int NC = 5;
  localparam int H  = 16;
  localparam int FL = G * (NC + 1);
  localparam int PW = $clog2(FL);
  localparam int NF = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inBit = 1'b0;
  logic          inValid = 1'b0;
  logic [PW-1:0] framePos = '0;
  logic          lof = 1'b0;
  logic [NT-1:0] tribData;
  logic [NT-1:0] tribWe;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  posJustDemux #(.NUM_TRIB(NT), .GROUP_LEN(G), .NUM_CTRL(NC), .HDR_BITS(H)) u0 (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid),
    .framePos(framePos), .lof(lof), .tribData(tribData), .tribWe(tribWe)
  );

  function automatic logic [4:0] codeOf(int f, int t);
    return 5'((f * 5 + t * 11) % 32);
  endfunction

  function automatic logic dataBitOf(int f, int p);
    return ((p * 37 + f * 101 + (p >> 3)) % 5) < 2;
  endfunction

  // One cycle: drive at negedge, check 1 ns after the next posedge.
  task automatic step(input int f, input int p, input logic v, input logic lf);
    logic [NT-1:0] expWe;
    logic          b;
    int            grp, off, tr;
    string         tag;
    grp = p / G;
    off = p % G;
    tr  = 0;
    b   = 1'b1;
    expWe = '0;
    tag = "R9";
    if (v) begin
      if (grp == 0 && off < H) begin
        tag = "R2"; b = dataBitOf(f, p);
      end else if (grp > 0 && off < NT) begin
        tag = "R4"; b = codeOf(f, off)[grp-1];
      end else if (grp == NC && off < 2 * NT) begin
        tr = off - NT;
        b  = dataBitOf(f, p);
        if ($countones(codeOf(f, tr)) >= 3) tag = "R5 R7";
        else begin tag = "R6 R7"; expWe[tr] = 1'b1; end
      end else begin
        tag = "R3"; tr = off % NT; b = dataBitOf(f, p); expWe[tr] = 1'b1;
      end
      if (lf) begin expWe = '0; tag = "R8"; end
    end
    @(negedge clk);
    inValid  = v;
    framePos = PW'(p);
    inBit    = b;
    lof      = lf;
    @(posedge clk);
    #1;
    vectors++;
    if (tribWe !== expWe || (expWe != '0 && tribData[tr] !== b)) begin
      fails++;
      $display("FAIL %s f=%0d pos=%0d we=%b/%b data=%b exp we=%b bit=%b",
               tag, f, p, tribWe, tribData, expWe, b, b);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    // R1: outputs after reset
    if (tribWe !== '0 || tribData !== '0) begin
      fails++;
      $display("FAIL R1 we=%b data=%b exp we=0000 data=0000", tribWe, tribData);
    end
    @(negedge clk);
    rstN = 1'b1;
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < FL; p++) begin
        // R9: idle cycle presenting a 1 at the upcoming position
        if ((p + f) % 7 == 3) step(f, p, 1'b0, 1'b0);
        step(f, p, 1'b1, (f >= 34 && f <= 35 && p >= 30 && p < 90));
      end
    end
    step(0, 0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule